// File: doc/BRIEF.md
# Combined Interrupt Channel Locator

This block turns a wide interrupt summary into the number of the logical mailbox channel that needs service. The summary carries one bit per channel window, spread over several 32-bit words. A fixed table, given as parameters, splits the windows into groups in table order. A group is either doorbell-style, where every bit of every window is its own channel, or data-transfer style, where the whole group is a single channel.

A lookup runs in two stages. First the block picks the lowest-numbered pending window. It then walks the table one entry per cycle, adding up the channel numbers used by the groups it passes, until it reaches the group that holds that window. For a doorbell window, the lowest set bit of that window's masked status word picks the exact channel. The block returns the channel number with an error flag in a one-cycle response pulse. It also checks the table and flags a configuration that cannot be valid.

Top module: `chan_locator`

## Requirements
- R1: The pending window is the lowest set bit of the whole summary vector. Bit b of word w is window 32*w+b, so a bit in a lower word always wins over a bit in a higher word.
- R2: A window in a doorbell group gives a channel of base + 32*(window - groupStart) + the index of the lowest set bit of that window's 32-bit status word. Window n's status word sits at bits 32*n+31..32*n of `winStat`.
- R3: Every window of a data-transfer group gives the same single channel, which is that group's base.
- R4: Groups take consecutive windows from 0 in table order. Each group's base is the sum over the earlier groups of 32*count for a doorbell group (kind code 0) and 1 for a data-transfer group (kind code 1).
- R5: A request with an all-zero summary returns an error.
- R6: A pending window that no table group covers returns an error. This includes implemented windows beyond the table and windows beyond the implemented count.
- R7: A doorbell window whose status word is zero returns an error.
- R8: `cfgError` is high when any group has a count of zero, any kind code is other than 0 or 1, or the counts add up to more than `NUM_WIN`. While it is high, every lookup returns an error.
- R9: A request is taken at the clock edge E0. The response pulse lasts exactly one cycle and follows edge E0 when the request fails at once (R5, R8). It follows edge E(i+1) when table entry i holds the window, and edge E(NUM_ENT) when no entry does.
- R10: `busy` is high from the edge that takes a request until the response pulse ends. A request raised while `busy` is high gets no response and does not change the result in progress.
- R11: After reset, `busy` and `rspValid` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| reqValid | input | 1 | Start a lookup (taken only while idle) |
| intSummary | input | SUM_WORDS*32 | Per-window pending summary |
| winStat | input | NUM_WIN*32 | Masked status word of each window |
| busy | output | 1 | Lookup in progress |
| rspValid | output | 1 | One-cycle result strobe |
| rspError | output | 1 | Result is an error |
| rspChan | output | CHAN_W | Located channel number |
| cfgError | output | 1 | Table parameters are invalid |

## Verification
The main instance uses four summary words, 16 implemented windows and a four-entry table that alternates doorbell and data-transfer groups and covers only 8 windows. With this table every walk length from one to four entries can be reached, along with both kinds of uncovered window and base values that mix both kinds of contribution. Three small two-entry instances each break the table in a different way: a zero count, a bad kind code, or more windows than are implemented. One of them also receives a lookup, which must come back as an error.

// File: rtl/chloc_pkg.sv
package chloc_pkg;
  localparam int WORD_BITS = 32;
  localparam logic [1:0] KIND_DOORBELL = 2'd0;
  localparam logic [1:0] KIND_DATA     = 2'd1;

  typedef struct packed {
    logic load;     // latch first pending window, restart walk
    logic step;     // advance to next table entry
    logic capture;  // store result from current entry
    logic fail;     // store an error result
  } chlocStrobe_t;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_WALK = 2'd1,
    ST_DONE = 2'd2
  } chlocState_t;
endpackage

// File: rtl/chloc_cfg_check.sv
module chloc_cfg_check
  import chloc_pkg::*;
#(
  parameter int NUM_WIN = 16,
  parameter int NUM_ENT = 4,
  parameter int CNT_W   = 7,
  parameter logic [NUM_ENT*2-1:0]     ENT_KINDS  = '0,
  parameter logic [NUM_ENT*CNT_W-1:0] ENT_COUNTS = '0
) (
  output logic cfgError
);
  localparam int SUM_W = CNT_W + $clog2(NUM_ENT + 1);

  logic [NUM_ENT-1:0] entBad;
  logic [SUM_W-1:0]   runTotal [NUM_ENT+1];

  assign runTotal[0] = '0;

  for (genvar e = 0; e < NUM_ENT; e++) begin : g_ent
    localparam logic [1:0]       KIND = ENT_KINDS[e*2 +: 2];
    localparam logic [CNT_W-1:0] CNT  = ENT_COUNTS[e*CNT_W +: CNT_W];
    assign entBad[e] = (CNT == '0) || ((KIND != KIND_DOORBELL) && (KIND != KIND_DATA));
    assign runTotal[e+1] = runTotal[e] + SUM_W'(CNT);
  end

  assign cfgError = (|entBad) || (int'(runTotal[NUM_ENT]) > NUM_WIN);
endmodule

// File: rtl/chloc_datapath.sv
module chloc_datapath
  import chloc_pkg::*;
#(
  parameter int SUM_WORDS = 4,
  parameter int NUM_WIN   = 16,
  parameter int NUM_ENT   = 4,
  parameter int CNT_W     = 7,
  parameter int WIN_W     = 7,
  parameter int ENT_W     = 2,
  parameter int OFF_W     = 10,
  parameter int CHAN_W    = 10,
  parameter logic [NUM_ENT*2-1:0]     ENT_KINDS  = '0,
  parameter logic [NUM_ENT*CNT_W-1:0] ENT_COUNTS = '0
) (
  input  logic                           clk,
  input  logic                           rstN,
  input  chlocStrobe_t                   strobe,
  input  logic [SUM_WORDS*WORD_BITS-1:0] intSummary,
  input  logic [NUM_WIN*WORD_BITS-1:0]   winStat,
  output logic                           anyHit,
  output logic                           inEntry,
  output logic                           lastEnt,
  output logic [CHAN_W-1:0]              rspChan,
  output logic                           rspError
);
  localparam int SUM_BITS = SUM_WORDS * WORD_BITS;
  localparam int BIT_W    = $clog2(WORD_BITS);

  // Table unpacked from parameters
  logic [1:0]       kindTab [NUM_ENT];
  logic [CNT_W-1:0] cntTab  [NUM_ENT];
  for (genvar e = 0; e < NUM_ENT; e++) begin : g_tab
    assign kindTab[e] = ENT_KINDS[e*2 +: 2];
    assign cntTab[e]  = ENT_COUNTS[e*CNT_W +: CNT_W];
  end

  // Stage one: lowest pending window
  logic [WIN_W-1:0] firstWin;
  always_comb begin
    firstWin = '0;
    anyHit   = 1'b0;
    for (int b = SUM_BITS - 1; b >= 0; b--) begin
      if (intSummary[b]) begin
        firstWin = WIN_W'(b);
        anyHit   = 1'b1;
      end
    end
  end

  // Walk state
  logic [WIN_W-1:0]  winNum;
  logic [ENT_W-1:0]  entIdx;
  logic [OFF_W-1:0]  offset;
  logic [CHAN_W-1:0] chanBase;

  logic [1:0]        curKind;
  logic [CNT_W-1:0]  curCnt;
  logic [OFF_W-1:0]  winExt;
  logic [OFF_W-1:0]  endOff;
  logic [OFF_W-1:0]  relWin;
  logic              isDoorbell;

  assign curKind    = kindTab[entIdx];
  assign curCnt     = cntTab[entIdx];
  assign isDoorbell = (curKind == KIND_DOORBELL);
  assign winExt     = OFF_W'(winNum);
  assign endOff     = offset + OFF_W'(curCnt);
  assign relWin     = winExt - offset;
  assign inEntry    = (winExt < endOff);
  assign lastEnt    = (entIdx == ENT_W'(NUM_ENT - 1));

  // Status word of the latched window
  logic [WORD_BITS-1:0] statWord;
  always_comb begin
    statWord = '0;
    for (int w = 0; w < NUM_WIN; w++) begin
      if (winNum == WIN_W'(w)) statWord = winStat[w*WORD_BITS +: WORD_BITS];
    end
  end

  // Stage two helper: lowest set doorbell bit
  logic [BIT_W-1:0] dbBit;
  logic             dbHit;
  always_comb begin
    dbBit = '0;
    dbHit = 1'b0;
    for (int b = WORD_BITS - 1; b >= 0; b--) begin
      if (statWord[b]) begin
        dbBit = BIT_W'(b);
        dbHit = 1'b1;
      end
    end
  end

  logic [CHAN_W-1:0] candChan;
  logic [CHAN_W-1:0] stepAdd;
  always_comb begin
    if (isDoorbell) begin
      candChan = chanBase + (CHAN_W'(relWin) << BIT_W) + CHAN_W'(dbBit);
      stepAdd  = CHAN_W'(curCnt) << BIT_W;
    end else begin
      candChan = chanBase;
      stepAdd  = CHAN_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      winNum   <= '0;
      entIdx   <= '0;
      offset   <= '0;
      chanBase <= '0;
      rspChan  <= '0;
      rspError <= 1'b0;
    end else begin
      if (strobe.load) begin
        winNum   <= firstWin;
        entIdx   <= '0;
        offset   <= '0;
        chanBase <= '0;
      end else if (strobe.step) begin
        entIdx   <= entIdx + 1'b1;
        offset   <= endOff;
        chanBase <= chanBase + stepAdd;
      end
      if (strobe.capture) begin
        rspChan  <= candChan;
        rspError <= isDoorbell && !dbHit;
      end else if (strobe.fail) begin
        rspChan  <= '0;
        rspError <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/chloc_ctrl.sv
module chloc_ctrl
  import chloc_pkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic         reqValid,
  input  logic         cfgError,
  input  logic         anyHit,
  input  logic         inEntry,
  input  logic         lastEnt,
  output chlocStrobe_t strobe,
  output logic         busy,
  output logic         rspValid
);
  chlocState_t state, nxtState;

  always_comb begin
    strobe   = '0;
    nxtState = state;
    unique case (state)
      ST_IDLE: begin
        if (reqValid) begin
          if (cfgError || !anyHit) begin
            strobe.fail = 1'b1;
            nxtState    = ST_DONE;
          end else begin
            strobe.load = 1'b1;
            nxtState    = ST_WALK;
          end
        end
      end
      ST_WALK: begin
        if (inEntry) begin
          strobe.capture = 1'b1;
          nxtState       = ST_DONE;
        end else if (lastEnt) begin
          strobe.fail = 1'b1;
          nxtState    = ST_DONE;
        end else begin
          strobe.step = 1'b1;
        end
      end
      ST_DONE: nxtState = ST_IDLE;
      default: nxtState = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= nxtState;
  end

  assign busy     = (state != ST_IDLE);
  assign rspValid = (state == ST_DONE);
endmodule

// File: rtl/chan_locator.sv
module chan_locator
  import chloc_pkg::*;
#(
  parameter int SUM_WORDS = 4,
  parameter int NUM_WIN   = 16,
  parameter int NUM_ENT   = 4,
  parameter int CNT_W     = 7,
  parameter logic [NUM_ENT*2-1:0]     ENT_KINDS  = {2'd1, 2'd0, 2'd1, 2'd0},
  parameter logic [NUM_ENT*CNT_W-1:0] ENT_COUNTS = {7'd2, 7'd1, 7'd3, 7'd2},
  localparam int WIN_W  = $clog2(SUM_WORDS * WORD_BITS),
  localparam int ENT_W  = (NUM_ENT > 1) ? $clog2(NUM_ENT) : 1,
  localparam int OFF_W  = ((CNT_W > WIN_W) ? CNT_W : WIN_W) + ENT_W + 1,
  localparam int CHAN_W = $clog2(WORD_BITS * NUM_WIN + NUM_ENT + 1)
) (
  input  logic                           clk,
  input  logic                           rstN,
  input  logic                           reqValid,
  input  logic [SUM_WORDS*WORD_BITS-1:0] intSummary,
  input  logic [NUM_WIN*WORD_BITS-1:0]   winStat,
  output logic                           busy,
  output logic                           rspValid,
  output logic                           rspError,
  output logic [CHAN_W-1:0]              rspChan,
  output logic                           cfgError
);
  chlocStrobe_t strobe;
  logic anyHit, inEntry, lastEnt;

  chloc_cfg_check #(
    .NUM_WIN(NUM_WIN), .NUM_ENT(NUM_ENT), .CNT_W(CNT_W),
    .ENT_KINDS(ENT_KINDS), .ENT_COUNTS(ENT_COUNTS)
  ) u_cfg (
    .cfgError(cfgError)
  );

  chloc_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .cfgError(cfgError),
    .anyHit(anyHit), .inEntry(inEntry), .lastEnt(lastEnt),
    .strobe(strobe), .busy(busy), .rspValid(rspValid)
  );

  chloc_datapath #(
    .SUM_WORDS(SUM_WORDS), .NUM_WIN(NUM_WIN), .NUM_ENT(NUM_ENT), .CNT_W(CNT_W),
    .WIN_W(WIN_W), .ENT_W(ENT_W), .OFF_W(OFF_W), .CHAN_W(CHAN_W),
    .ENT_KINDS(ENT_KINDS), .ENT_COUNTS(ENT_COUNTS)
  ) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .intSummary(intSummary),
    .winStat(winStat), .anyHit(anyHit), .inEntry(inEntry), .lastEnt(lastEnt),
    .rspChan(rspChan), .rspError(rspError)
  );
endmodule

// File: rtl/chloc_checker.sv
module chloc_checker (
  input logic clk,
  input logic rstN,
  input logic reqValid,
  input logic busy,
  input logic rspValid,
  input logic rspError,
  input logic cfgError
);
  // R9: response strobe lasts one cycle
  p_pulse_r9: assert property (@(posedge clk) disable iff (!rstN)
    rspValid |=> !rspValid);

  // R9: block returns to idle after the response
  p_idle_after_r9: assert property (@(posedge clk) disable iff (!rstN)
    rspValid |=> !busy);

  // R10: an accepted request makes the block busy
  p_accept_r10: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && !busy) |=> busy);

  // R10: a response only appears while busy
  p_valid_busy_r10: assert property (@(posedge clk) disable iff (!rstN)
    rspValid |-> busy);

  // R8: bad table forces error responses
  p_cfg_err_r8: assert property (@(posedge clk) disable iff (!rstN)
    (rspValid && cfgError) |-> rspError);
endmodule

bind chan_locator chloc_checker u_chk (
  .clk(clk), .rstN(rstN), .reqValid(reqValid), .busy(busy),
  .rspValid(rspValid), .rspError(rspError), .cfgError(cfgError)
);

// File: tb/chan_locator_bench.sv
module chan_locator_bench;
  localparam int SUM_BITS = 128;
  localparam int STAT_BITS = 16 * 32;
  localparam int CHAN_W = 10;
  localparam int TK [4] = '{0, 1, 0, 1};
  localparam int TC [4] = '{2, 3, 1, 2};

  logic clk = 1'b0;
  logic rstN = 1'b0;
  always #5 clk = ~clk;

  logic                 reqValid = 1'b0;
  logic [SUM_BITS-1:0]  summary = '0;
  logic [STAT_BITS-1:0] stat = '0;
  logic busy, rspValid, rspError, cfgError;
  logic [CHAN_W-1:0] rspChan;

  chan_locator u_chan_locator (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .intSummary(summary),
    .winStat(stat), .busy(busy), .rspValid(rspValid), .rspError(rspError),
    .rspChan(rspChan), .cfgError(cfgError)
  );

  // Misconfigured instances
  logic badReq = 1'b0;
  logic zBusy, zValid, zErr, zCfg, kBusy, kValid, kErr, kCfg, sBusy, sValid, sErr, sCfg;
  logic [8:0] zChan, kChan;
  logic [7:0] sChan;

  chan_locator #(.NUM_ENT(2), .ENT_KINDS({2'd0, 2'd1}), .ENT_COUNTS({7'd2, 7'd0})) u_badZero (
    .clk(clk), .rstN(rstN), .reqValid(badReq), .intSummary(128'h1), .winStat('0),
    .busy(zBusy), .rspValid(zValid), .rspError(zErr), .rspChan(zChan), .cfgError(zCfg));
  chan_locator #(.NUM_ENT(2), .ENT_KINDS({2'd0, 2'd2}), .ENT_COUNTS({7'd1, 7'd1})) u_badKind (
    .clk(clk), .rstN(rstN), .reqValid(1'b0), .intSummary('0), .winStat('0),
    .busy(kBusy), .rspValid(kValid), .rspError(kErr), .rspChan(kChan), .cfgError(kCfg));
  chan_locator #(.NUM_WIN(4), .NUM_ENT(2), .ENT_KINDS({2'd1, 2'd0}), .ENT_COUNTS({7'd2, 7'd3})) u_badSize (
    .clk(clk), .rstN(rstN), .reqValid(1'b0), .intSummary('0), .winStat('0),
    .busy(sBusy), .rspValid(sValid), .rspError(sErr), .rspChan(sChan), .cfgError(sCfg));

  typedef struct {
    logic  err;
    int    chan;
    int    lat;
    int    issue;
    string tag;
  } expItem_t;

  expItem_t sbq [$];
  expItem_t cur;
  int checks = 0;
  int fails = 0;
  int cycleCnt = 0;
  bit finished = 0;

  always @(posedge clk) cycleCnt <= cycleCnt + 1;

  // Reference model built from the requirements
  function automatic void model(input logic [SUM_BITS-1:0] s, input logic [STAT_BITS-1:0] st,
                                output logic err, output int chan, output int lat);
    int win;
    int off;
    int base;
    int bitIdx;
    logic [31:0] word;
    win = -1; off = 0; base = 0; bitIdx = -1;
    err = 1'b1; chan = 0; lat = 1;
    for (int b = 0; b < SUM_BITS; b++) if (s[b] && win < 0) win = b;
    if (win < 0) return;
    for (int e = 0; e < 4; e++) begin
      if (win < off + TC[e]) begin
        lat = e + 2;
        if (TK[e] == 0) begin
          word = st[win*32 +: 32];
          for (int b = 0; b < 32; b++) if (word[b] && bitIdx < 0) bitIdx = b;
          if (bitIdx >= 0) begin
            err = 1'b0;
            chan = base + 32 * (win - off) + bitIdx;
          end
        end else begin
          err = 1'b0;
          chan = base;
        end
        return;
      end
      base += (TK[e] == 0) ? 32 * TC[e] : 1;
      off += TC[e];
    end
    lat = 5;
  endfunction

  task automatic check(input bit ok, input string msg, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual=%0d expected=%0d", msg, act, exp);
    end
  endtask

  // Monitor: compares each response against the queue head
  always @(negedge clk) begin
    if (rstN && rspValid && !finished) begin
      if (sbq.size() == 0) begin
        check(1'b0, "R10 unexpected response", 1, 0);
      end else begin
        cur = sbq.pop_front();
        check(rspError === cur.err, {cur.tag, " error flag"}, int'(rspError), int'(cur.err));
        if (!cur.err) check(int'(rspChan) == cur.chan, {cur.tag, " channel"}, int'(rspChan), cur.chan);
        check(cycleCnt - cur.issue == cur.lat, {cur.tag, " R9 latency"}, cycleCnt - cur.issue, cur.lat);
      end
    end
  end

  task automatic issue(input logic [SUM_BITS-1:0] s, input string tag);
    expItem_t it;
    @(negedge clk);
    summary = s;
    model(s, stat, it.err, it.chan, it.lat);
    it.issue = cycleCnt;
    it.tag = tag;
    sbq.push_back(it);
    reqValid = 1'b1;
    @(negedge clk);
    reqValid = 1'b0;
    while (busy) @(negedge clk);
  endtask

  function automatic logic [SUM_BITS-1:0] winBit(input int w);
    logic [SUM_BITS-1:0] v;
    v = '0;
    v[w] = 1'b1;
    return v;
  endfunction

  initial begin
    repeat (3) @(negedge clk);
    // R11: reset state
    check(busy === 1'b0 && rspValid === 1'b0, "R11 reset outputs", int'(busy) + int'(rspValid), 0);
    rstN = 1'b1;
    @(negedge clk);
    check(busy === 1'b0, "R11 idle after reset", int'(busy), 0);

    stat[0*32 +: 32] = 32'h0000_0020;
    stat[1*32 +: 32] = 32'h8000_0008;
    stat[5*32 +: 32] = 32'h0000_0001;

    issue(winBit(0), "R2 doorbell window0");
    issue(winBit(1), "R2 doorbell window1 lowest bit");
    issue(winBit(3), "R3 data group window3");
    issue(winBit(5), "R4 base after mixed groups");
    issue(winBit(7), "R4 last data group");
    issue(winBit(7) | winBit(2), "R1 lowest window wins");
    issue(winBit(5) | winBit(40), "R1 lower word priority");
    issue(winBit(32) | winBit(70), "R6 window beyond implemented");
    issue(winBit(10), "R6 uncovered implemented window");
    issue(winBit(96), "R6 top word only");
    issue('0, "R5 empty summary");
    stat[0*32 +: 32] = '0;
    issue(winBit(0), "R7 doorbell status empty");

    // R10: requests during a walk are ignored
    begin
      expItem_t it;
      @(negedge clk);
      summary = winBit(7);
      model(summary, stat, it.err, it.chan, it.lat);
      it.issue = cycleCnt;
      it.tag = "R10 first request kept";
      sbq.push_back(it);
      reqValid = 1'b1;
      @(negedge clk);
      summary = winBit(5);
      @(negedge clk);
      check(busy === 1'b1, "R10 busy during walk", int'(busy), 1);
      reqValid = 1'b0;
      while (busy) @(negedge clk);
      repeat (4) @(negedge clk);
      check(sbq.size() == 0, "R10 queue drained", sbq.size(), 0);
    end

    // R8: configuration checks
    check(cfgError === 1'b0, "R8 valid table", int'(cfgError), 0);
    check(zCfg === 1'b1, "R8 zero count", int'(zCfg), 1);
    check(kCfg === 1'b1, "R8 bad kind", int'(kCfg), 1);
    check(sCfg === 1'b1, "R8 too many windows", int'(sCfg), 1);
    @(negedge clk);
    badReq = 1'b1;
    @(negedge clk);
    badReq = 1'b0;
    check(zValid === 1'b1 && zErr === 1'b1, "R8 lookup errors on bad table",
          int'(zValid) + int'(zErr), 2);

    repeat (3) @(negedge clk);
    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      checks++;
      fails++;
      $display("FAIL R9 watchdog: actual=hung expected=done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end
endmodule